// File: doc/BRIEF.md
# Event and Slow-Control Packet Formatter

This block merges two data sources onto one fixed-rate serial link toward the floor controller. One source is captured PMT events that a show-ahead FIFO holds. The other is slow-control words that the local processor offers through a valid/ready handshake. The block wraps each item in a small frame and sends the frames one bit at a time. A single-cycle bit-rate strobe sets the pace; for the 19.44 Mbit/s link it comes from a divider on the system clock. When neither source has anything waiting, the line carries an idle level.

Every frame begins with a start bit of 0. A type bit follows, 1 for an event and 0 for a slow-control word. The payload then goes out most significant bit first. Events take priority, because physics data dominates the traffic. The link has spare capacity, so the `SC_EVERY` parameter sets the share left for slow control. While a slow-control word is waiting, no more than `SC_EVERY-1` event frames go out in a row. Frames are never interrupted. The choice of the next source is made only where one frame ends and the next can begin.

Top module: `evsc_pkt_formatter`

## Requirements
- R1: While `rstN` is low, `serOut` is 1 and neither `fifoRd` nor `scReady` is asserted, even with `bitEn` high and data offered.
- R2: With no event and no slow-control word waiting, `serOut` stays at 1 (idle) and no frame starts.
- R3: A frame is a start bit 0, then a type bit (1 = event, 0 = slow control), then the payload MSB first: `EVT_W` bits for an event, `SC_W` bits for slow control.
- R4: `serOut` changes only in the cycle after one in which `bitEn` was high, so each line bit lasts exactly one strobe interval.
- R5: A source is consumed (`fifoRd` or `scReady` high) only in a cycle with `bitEn` high in which the line carries an idle bit or the last payload bit of a frame. A word that arrives mid-frame waits for that frame to end.
- R6: When both sources wait and the slow-control quota is not due, the event is sent first.
- R7: While a slow-control word waits, at most `SC_EVERY-1` event frames go out in a row before it is served. With both sources always full and `SC_EVERY`=4, the order is E,E,E,S repeating.
- R8: When a source is waiting at the end of a frame, the next frame's start bit follows the last payload bit with no idle bit between them.
- R9: `fifoRd` is asserted only while the FIFO is not empty, and `scReady` only while `scValid` is high. Each such cycle consumes exactly one item, and the item goes out in one frame.
- R10: The event-run count is cleared only by a slow-control frame. A slow-control word that arrives after `SC_EVERY-1` or more uninterrupted event frames is sent at the next boundary, ahead of waiting events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Bit-rate strobe; one line bit is consumed per high cycle |
| fifoEmpty | input | 1 | Event FIFO holds no entry |
| fifoData | input | EVT_W | Head entry of the event FIFO (show-ahead) |
| fifoRd | output | 1 | Pops the head entry of the event FIFO |
| scData | input | SC_W | Slow-control word offered |
| scValid | input | 1 | Slow-control word is valid |
| scReady | output | 1 | Slow-control word is taken this cycle |
| serOut | output | 1 | Serial output bit toward the floor controller |

## Verification
A bad bit counter shows at the ports within one frame. The decoded frame comes out too long or too short, its payload is shifted, or a type bit lands in the wrong position. A faulty run counter or priority choice changes the type sequence within `SC_EVERY` frames, as soon as both sources are waiting. A pop outside a boundary is visible in the same cycle. It also leaves a frame unsent, which shows up as a missing or repeated payload in the stream.

// File: rtl/evsc_fmt_pkg.sv
package evsc_fmt_pkg;

  // line levels and frame header values
  localparam logic START_BIT = 1'b0;
  localparam logic IDLE_BIT  = 1'b1;
  localparam logic TYPE_EVT  = 1'b1;
  localparam logic TYPE_SC   = 1'b0;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEvt;
    logic loadSc;
    logic shift;
  } fmtStrobe_t;

endpackage

// File: rtl/evsc_fmt_ctrl.sv
module evsc_fmt_ctrl
  import evsc_fmt_pkg::*;
#(
  parameter int unsigned SC_EVERY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       fifoEmpty,
  input  logic       scValid,
  input  logic       lastBit,
  output logic       fifoRd,
  output logic       scReady,
  output fmtStrobe_t strobe
);

  localparam int unsigned RUN_W = $clog2(SC_EVERY + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SC_EVERY - 1);

  logic [RUN_W-1:0] runCnt;
  logic boundary;
  logic scDue;
  logic pickSc;
  logic pickEvt;

  // a new frame may start only when the current bit is idle or final
  always_comb begin
    boundary = rstN && bitEn && lastBit;
    scDue    = (runCnt >= RUN_MAX);
    pickSc   = scValid && (fifoEmpty || scDue);
    pickEvt  = !fifoEmpty && !pickSc;
    strobe.loadEvt = boundary && pickEvt;
    strobe.loadSc  = boundary && pickSc;
    strobe.shift   = rstN && bitEn && !(strobe.loadEvt || strobe.loadSc);
  end

  assign fifoRd  = strobe.loadEvt;
  assign scReady = strobe.loadSc;

  // consecutive event frames since the last slow-control frame, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.loadSc) begin
      runCnt <= '0;
    end else if (strobe.loadEvt && (runCnt < RUN_MAX)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // checker: event frames sent while a slow-control word is pending
  logic [RUN_W:0] waitRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitRun <= '0;
    end else if (strobe.loadSc || !scValid) begin
      waitRun <= '0;
    end else if (strobe.loadEvt && (waitRun != '1)) begin
      waitRun <= waitRun + 1'b1;
    end
  end

  a_r7_sc_not_starved: assert property (@(posedge clk) disable iff (!rstN)
    waitRun <= {1'b0, RUN_MAX});

  a_r9_fifo_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);

endmodule

// File: rtl/evsc_fmt_datapath.sv
module evsc_fmt_datapath
  import evsc_fmt_pkg::*;
#(
  parameter int unsigned EVT_W = 96,
  parameter int unsigned SC_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fmtStrobe_t       strobe,
  input  logic [EVT_W-1:0] fifoData,
  input  logic [SC_W-1:0]  scData,
  output logic             serOut,
  output logic             lastBit
);

  localparam int unsigned PAY_W = (EVT_W > SC_W) ? EVT_W : SC_W;
  localparam int unsigned SH_W  = PAY_W + 2;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] EVT_LEN = CNT_W'(EVT_W + 2);
  localparam logic [CNT_W-1:0] SC_LEN  = CNT_W'(SC_W + 2);

  logic [SH_W-1:0]  shreg;
  logic [CNT_W-1:0] bitsLeft;
  logic [SH_W-1:0]  evtFrame;
  logic [SH_W-1:0]  scFrame;

  // frames are left-aligned so the MSB is always the bit on the line
  always_comb begin
    evtFrame = '0;
    evtFrame[SH_W-1 -: EVT_W+2] = {START_BIT, TYPE_EVT, fifoData};
    scFrame = '0;
    scFrame[SH_W-1 -: SC_W+2] = {START_BIT, TYPE_SC, scData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg    <= '0;
      bitsLeft <= '0;
    end else if (strobe.loadEvt) begin
      shreg    <= evtFrame;
      bitsLeft <= EVT_LEN;
    end else if (strobe.loadSc) begin
      shreg    <= scFrame;
      bitsLeft <= SC_LEN;
    end else if (strobe.shift && (bitsLeft != '0)) begin
      shreg    <= {shreg[SH_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign serOut  = (bitsLeft != '0) ? shreg[SH_W-1] : IDLE_BIT;
  assign lastBit = (bitsLeft <= CNT_W'(1));

  a_r5_load_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEvt || strobe.loadSc) |-> (bitsLeft <= CNT_W'(1)));

  a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.shift || strobe.loadEvt || strobe.loadSc) |-> $stable(serOut));

  a_r3_start_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadEvt || strobe.loadSc) |-> (serOut == START_BIT));

endmodule

// File: rtl/evsc_pkt_formatter.sv
module evsc_pkt_formatter
  import evsc_fmt_pkg::*;
#(
  parameter int unsigned EVT_W    = 96,
  parameter int unsigned SC_W     = 16,
  parameter int unsigned SC_EVERY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             fifoEmpty,
  input  logic [EVT_W-1:0] fifoData,
  output logic             fifoRd,
  input  logic [SC_W-1:0]  scData,
  input  logic             scValid,
  output logic             scReady,
  output logic             serOut
);

  fmtStrobe_t strobe;
  logic       lastBit;

  evsc_fmt_ctrl #(
    .SC_EVERY(SC_EVERY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .fifoEmpty(fifoEmpty),
    .scValid  (scValid),
    .lastBit  (lastBit),
    .fifoRd   (fifoRd),
    .scReady  (scReady),
    .strobe   (strobe)
  );

  evsc_fmt_datapath #(
    .EVT_W(EVT_W),
    .SC_W (SC_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fifoData(fifoData),
    .scData  (scData),
    .serOut  (serOut),
    .lastBit (lastBit)
  );

endmodule

// File: tb/evsc_pkt_formatter_test.sv
module evsc_pkt_formatter_test;

  localparam int EVT_W    = 96;
  localparam int SC_W     = 16;
  localparam int SC_EVERY = 4;
  localparam int MAXP     = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic [EVT_W-1:0] fifoData;
  logic fifoEmpty;
  logic fifoRd;
  logic [SC_W-1:0] scData;
  logic scValid;
  logic scReady;
  logic serOut;

  always #5 clk = ~clk;

  evsc_pkt_formatter #(.EVT_W(EVT_W), .SC_W(SC_W), .SC_EVERY(SC_EVERY)) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoRd(fifoRd), .scData(scData), .scValid(scValid),
    .scReady(scReady), .serOut(serOut)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [EVT_W-1:0] evtVal(input int k);
    return {32'hE0000000 | 32'(k), ~32'(k), 32'h5A5A0000 + 32'(k)};
  endfunction

  function automatic logic [SC_W-1:0] scVal(input int k);
    return 16'hC000 + 16'(k * 3);
  endfunction

  // source models: show-ahead FIFO and slow-control queue
  logic [EVT_W-1:0] evtMem [MAXP];
  logic [SC_W-1:0]  scMem  [MAXP];
  int evtWr = 0, evtRdP = 0, scWr = 0, scRdP = 0;

  assign fifoEmpty = (evtWr == evtRdP);
  assign fifoData  = evtMem[evtRdP % MAXP];
  assign scValid   = (scWr != scRdP);
  assign scData    = scMem[scRdP % MAXP];

  always @(posedge clk) begin
    if (fifoRd && !fifoEmpty) evtRdP <= evtRdP + 1;
    if (scReady && scValid) scRdP <= scRdP + 1;
  end

  // bit-rate strobe generator
  bit genEn = 0;
  int div = 1;
  int divCnt = 0;
  always @(posedge clk) begin
    if (genEn) begin
      bitEn  <= (divCnt == 0);
      divCnt <= (divCnt + 1 >= div) ? 0 : divCnt + 1;
    end else begin
      bitEn  <= 1'b0;
      divCnt <= 0;
    end
  end

  // independent line decoder and port monitors
  int dState = 0, dLeft = 0, idleRun = 0;
  logic dType;
  logic [EVT_W-1:0] dPay;
  int nPkt = 0;
  logic pktType [MAXP];
  logic [EVT_W-1:0] pktData [MAXP];
  int pktGap [MAXP];
  int holdViol = 0, popViol = 0, hsViol = 0;
  logic prevSer = 1'b1;
  logic prevEn = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      // R4 monitor
      if (serOut !== prevSer && !prevEn) holdViol++;
      // R9 monitor
      if ((fifoRd && fifoEmpty) || (scReady && !scValid) || (fifoRd && scReady)) hsViol++;
      if (fifoRd || scReady) begin
        // R5 monitor: pop only on a strobe at an idle or final bit
        if (!bitEn) popViol++;
        else if (!((dState == 0 && serOut) || (dState == 2 && dLeft == 1))) popViol++;
      end
      if (bitEn) begin
        case (dState)
          0: if (serOut == 1'b0) begin
               dState = 1;
               if (nPkt < MAXP) pktGap[nPkt] = idleRun;
               idleRun = 0;
             end else idleRun++;
          1: begin
               dType = serOut;
               dLeft = serOut ? EVT_W : SC_W;
               dPay = '0;
               dState = 2;
             end
          default: begin
               dPay = {dPay[EVT_W-2:0], serOut};
               dLeft--;
               if (dLeft == 0) begin
                 if (nPkt < MAXP) begin
                   pktType[nPkt] = dType;
                   pktData[nPkt] = dPay;
                 end
                 nPkt++;
                 dState = 0;
               end
             end
        endcase
      end
    end
    prevSer = serOut;
    prevEn = bitEn;
  end

  task automatic pushEvt(input int n);
    for (int i = 0; i < n; i++) begin
      evtMem[evtWr % MAXP] = evtVal(evtWr);
      evtWr++;
    end
  endtask

  task automatic pushSc(input int n);
    for (int i = 0; i < n; i++) begin
      scMem[scWr % MAXP] = scVal(scWr);
      scWr++;
    end
  endtask

  task automatic waitPkts(input int target);
    for (int c = 0; c < 6000 && nPkt < target; c++) @(negedge clk);
  endtask

  int evtGot = 0, scGot = 0;

  // R3: compare each decoded frame with the next expected item of its type
  task automatic checkData(input int from, input int to);
    for (int i = from; i < to; i++) begin
      if (pktType[i]) begin
        chk(pktData[i] == evtVal(evtGot), "R3", "event payload", pktData[i], evtVal(evtGot));
        evtGot++;
      end else begin
        chk(pktData[i][SC_W-1:0] == scVal(scGot), "R3", "slow-control payload",
            pktData[i][SC_W-1:0], scVal(scGot));
        scGot++;
      end
    end
  endtask

  // {div, nEvt, nSc, nPkt, typeMask(bit i = frame i, 1 = event)}
  localparam logic [31:0] VEC [5] = '{
    {4'd1, 4'd6, 4'd2, 4'd8, 16'h0077},  // R7: E,E,E,S repeating
    {4'd1, 4'd0, 4'd3, 4'd3, 16'h0000},  // slow control only
    {4'd2, 4'd2, 4'd3, 4'd5, 16'h0003},  // R6: events first, then slow control
    {4'd1, 4'd5, 4'd0, 4'd5, 16'h001F},  // events only, run counter saturates
    {4'd3, 4'd3, 4'd1, 4'd4, 16'h000E}   // R10: saturated run -> slow control first
  };

  initial begin
    // R1: reset state with strobe running
    genEn = 1;
    div = 1;
    repeat (5) @(negedge clk);
    chk(serOut == 1'b1, "R1", "serOut in reset", serOut, 1);
    chk(fifoRd == 1'b0 && scReady == 1'b0, "R1", "pops in reset", {fifoRd, scReady}, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: idle line
    repeat (200) @(negedge clk);
    chk(nPkt == 0, "R2", "frames while idle", nPkt, 0);
    chk(serOut == 1'b1, "R2", "idle level", serOut, 1);
    genEn = 0;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 5; v++) begin
      int start, n;
      logic [15:0] mask, got;
      div = int'(VEC[v][31:28]);
      start = nPkt;
      n = int'(VEC[v][19:16]);
      mask = VEC[v][15:0];
      pushEvt(int'(VEC[v][27:24]));
      pushSc(int'(VEC[v][23:20]));
      @(negedge clk);
      genEn = 1;
      waitPkts(start + n);
      repeat (20) @(negedge clk);
      genEn = 0;
      repeat (3) @(negedge clk);
      chk(nPkt == start + n, "R3", "frame count", nPkt, start + n);
      got = '0;
      for (int i = 0; i < n; i++) got[i] = pktType[start + i];
      chk(got == mask, "R7", "type order (R6 R10)", got, mask);
      for (int i = 1; i < n; i++)
        chk(pktGap[start + i] == 0, "R8", "idle bits between frames", pktGap[start + i], 0);
      checkData(start, nPkt);
    end

    // R5: slow-control word arriving mid-frame waits for the boundary
    begin
      int start;
      start = nPkt;
      div = 1;
      pushEvt(1);
      @(negedge clk);
      genEn = 1;
      repeat (30) @(negedge clk);
      pushSc(1);
      @(negedge clk);
      chk(scValid == 1'b1, "R5", "slow-control still pending mid-frame", scValid, 1);
      waitPkts(start + 2);
      repeat (20) @(negedge clk);
      genEn = 0;
      chk(nPkt == start + 2 && pktType[start] == 1'b1 && pktType[start + 1] == 1'b0,
          "R5", "event then slow control", {pktType[start], pktType[start + 1]}, 2'b10);
      chk(pktGap[start + 1] == 0, "R8", "slow control follows at boundary", pktGap[start + 1], 0);
      checkData(start, nPkt);
    end

    chk(holdViol == 0, "R4", "line changed without strobe", holdViol, 0);
    chk(popViol == 0, "R5", "pop away from frame boundary", popViol, 0);
    chk(hsViol == 0, "R9", "pop without data", hsViol, 0);
    chk(evtRdP == evtWr && scRdP == scWr, "R9", "all items consumed once",
        {evtRdP, scRdP}, {evtWr, scWr});

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule